// File: doc/BRIEF.md
# Precise Exception Tracking Unit

This unit rides alongside a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each pipe register carries the instruction address, an exception code and two flags: whether the instruction sits in a branch delay slot, and whether it is a return-from-exception. Faults are reported by outside detectors as single-cycle strobes in the stage where they occur. Fetch faults arrive in fetch, illegal opcodes and overflow in execute, and bad data addresses in memory. The first code an instruction collects stays with it down the pipe. Nothing happens until the instruction reaches writeback.

When a faulting instruction reaches writeback, the unit does five things in that cycle. It blocks the register write, flushes every younger instruction and blocks any store in the memory stage. It redirects fetch to one fixed handler address. On the next edge it loads the exception PC and cause, enters kernel mode and disables interrupts. An external interrupt is taken on the instruction in writeback when no internal exception commits in that cycle, and it aborts that instruction. A return-from-exception reaching writeback redirects fetch to the saved exception PC, restores user mode and re-enables interrupts.

Every pipe advances on each clock. A taken-branch squash input cancels the instructions in fetch and decode, together with any exception they carry.

Top module: `exc_tracker`

## Requirements
- R1: Out of reset, kernel_mode is 1, irq_enable is 0, epc and cause are 0, and redirect and wb_write_ok are 0.
- R2: Cause codes are 1 for a fetch fault, 2 for an illegal opcode, 3 for overflow, 4 for a data-address fault and 5 for an external interrupt. An instruction keeps the code of the earliest stage that faulted, and later strobes on it are ignored.
- R3: An exception is acted on only in the cycle its instruction is in writeback. In that cycle redirect is 1, redirect_pc equals HANDLER_PC and wb_write_ok is 0.
- R4: Every instruction younger than a committing exception is flushed. None of them writes back, and no code they carry is ever raised.
- R5: Instructions older than a faulting one complete, with wb_write_ok 1 in their writeback cycle.
- R6: Instructions cancelled by br_squash, which acts on the fetch and decode stages, never reach writeback and never raise their exception.
- R7: On an internal exception, epc takes the faulting instruction's address. If that instruction is marked as a delay slot, epc takes that address minus INSN_BYTES, the address of the branch.
- R8: On the edge after an exception or interrupt commits, cause takes the committed code, kernel_mode becomes 1 and irq_enable becomes 0.
- R9: A return-from-exception, flagged by id_is_eret while it is in decode, redirects to epc when it reaches writeback. It flushes younger instructions, and on the next edge kernel_mode becomes 0 and irq_enable becomes 1.
- R10: ext_irq is taken only when irq_enable is 1, a valid instruction is in writeback and no internal exception commits in that cycle. The instruction in writeback is then aborted, and epc takes its address, or the address minus INSN_BYTES if it is a delay slot. Otherwise ext_irq has no effect.
- R11: mem_store_ok is 1 only when mem_store is requested for a valid memory-stage instruction that has no exception code and no redirect is happening in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | An instruction is fetched this cycle |
| if_pc | input | AW | Address of the fetched instruction |
| if_fetch_fault | input | 1 | The fetch faulted |
| if_in_slot | input | 1 | The fetched instruction is in a branch delay slot |
| id_is_eret | input | 1 | The decode-stage instruction is a return-from-exception |
| br_squash | input | 1 | Cancel the fetch- and decode-stage instructions |
| ex_illegal | input | 1 | Illegal opcode in execute |
| ex_overflow | input | 1 | Arithmetic overflow in execute |
| mem_addr_fault | input | 1 | Bad data address in memory stage |
| mem_store | input | 1 | The memory-stage instruction wants to store |
| ext_irq | input | 1 | External interrupt request |
| redirect | output | 1 | Flush and redirect fetch this cycle |
| redirect_pc | output | AW | Fetch target when redirect is 1 |
| mem_store_ok | output | 1 | The store may write memory |
| wb_write_ok | output | 1 | The writeback-stage instruction may write registers |
| epc | output | AW | Saved exception PC |
| cause | output | CODE_W | Code of the last committed exception |
| kernel_mode | output | 1 | 1 in kernel mode |
| irq_enable | output | 1 | External interrupts enabled |

## Verification
The bench builds the unit with its defaults: 32-bit addresses, 4-byte instructions, a 4-bit code and the handler at 0x80. With these values, a delay-slot fault lands epc exactly one word below the slot, and each of the five codes can be told apart in cause. The four-cycle walk from fetch to writeback makes each race visible at fixed cycles. These include an older fault against a younger fetch fault, an interrupt against an internal fault, and a squashed fault against a later clean instruction.

// File: rtl/exc_tracker.sv
module exc_tracker #(
  parameter int AW = 32,
  parameter int CODE_W = 4,
  parameter int INSN_BYTES = 4,
  parameter logic [AW-1:0] HANDLER_PC = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_valid,
  input  logic [AW-1:0]     if_pc,
  input  logic              if_fetch_fault,
  input  logic              if_in_slot,
  input  logic              id_is_eret,
  input  logic              br_squash,
  input  logic              ex_illegal,
  input  logic              ex_overflow,
  input  logic              mem_addr_fault,
  input  logic              mem_store,
  input  logic              ext_irq,
  output logic              redirect,
  output logic [AW-1:0]     redirect_pc,
  output logic              mem_store_ok,
  output logic              wb_write_ok,
  output logic [AW-1:0]     epc,
  output logic [CODE_W-1:0] cause,
  output logic              kernel_mode,
  output logic              irq_enable
);
  localparam logic [CODE_W-1:0] C_NONE  = CODE_W'(0);
  localparam logic [CODE_W-1:0] C_FETCH = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_ILL   = CODE_W'(2);
  localparam logic [CODE_W-1:0] C_OVF   = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_DADDR = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_IRQ   = CODE_W'(5);
  localparam logic [AW-1:0]     STEP    = AW'(INSN_BYTES);
  localparam int ID = 0, EX = 1, MEM = 2, WB = 3;

  logic [3:0]        v_q, bd_q, er_q;
  logic [AW-1:0]     pc_q   [4];
  logic [CODE_W-1:0] code_q [4];

  logic [CODE_W-1:0] if_code, ex_code, mem_code;
  logic exc_commit, irq_take, take, eret_commit, kill_front;
  logic [AW-1:0] epc_next;

  assign if_code  = if_fetch_fault ? C_FETCH : C_NONE;
  assign ex_code  = (code_q[EX] != C_NONE) ? code_q[EX] :
                    ex_illegal ? C_ILL : ex_overflow ? C_OVF : C_NONE;
  assign mem_code = (code_q[MEM] != C_NONE) ? code_q[MEM] :
                    mem_addr_fault ? C_DADDR : C_NONE;

  assign exc_commit  = v_q[WB] && (code_q[WB] != C_NONE);
  assign irq_take    = ext_irq && irq_enable && v_q[WB] && !exc_commit;
  assign take        = exc_commit || irq_take;
  assign eret_commit = v_q[WB] && er_q[WB] && !take;
  assign redirect    = take || eret_commit;
  assign redirect_pc = take ? HANDLER_PC : epc;
  assign kill_front  = redirect || br_squash;
  assign epc_next    = bd_q[WB] ? pc_q[WB] - STEP : pc_q[WB];

  assign wb_write_ok  = v_q[WB] && !take;
  assign mem_store_ok = mem_store && v_q[MEM] && (mem_code == C_NONE) && !redirect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      bd_q <= '0;
      er_q <= '0;
      for (int i = 0; i < 4; i++) begin
        pc_q[i]   <= '0;
        code_q[i] <= C_NONE;
      end
      epc         <= '0;
      cause       <= C_NONE;
      kernel_mode <= 1'b1;
      irq_enable  <= 1'b0;
    end else begin
      v_q[ID]     <= if_valid && !kill_front;
      pc_q[ID]    <= if_pc;
      code_q[ID]  <= if_code;
      bd_q[ID]    <= if_in_slot;
      er_q[ID]    <= 1'b0;

      v_q[EX]     <= v_q[ID] && !kill_front;
      pc_q[EX]    <= pc_q[ID];
      code_q[EX]  <= code_q[ID];
      bd_q[EX]    <= bd_q[ID];
      er_q[EX]    <= id_is_eret;

      v_q[MEM]    <= v_q[EX] && !redirect;
      pc_q[MEM]   <= pc_q[EX];
      code_q[MEM] <= ex_code;
      bd_q[MEM]   <= bd_q[EX];
      er_q[MEM]   <= er_q[EX];

      v_q[WB]     <= v_q[MEM] && !redirect;
      pc_q[WB]    <= pc_q[MEM];
      code_q[WB]  <= mem_code;
      bd_q[WB]    <= bd_q[MEM];
      er_q[WB]    <= er_q[MEM];

      if (take) begin
        epc         <= epc_next;
        cause       <= exc_commit ? code_q[WB] : C_IRQ;
        kernel_mode <= 1'b1;
        irq_enable  <= 1'b0;
      end else if (eret_commit) begin
        kernel_mode <= 1'b0;
        irq_enable  <= 1'b1;
      end
    end
  end

  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !v_q[WB]) else $error("younger instruction survived a redirect");

  p_epc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_commit && !bd_q[WB]) |=> epc == $past(pc_q[WB])) else $error("epc mismatch");

  p_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> kernel_mode && !irq_enable) else $error("mode not entered");

  p_eret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eret_commit |=> !kernel_mode && irq_enable) else $error("return did not restore user mode");

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> cause == C_IRQ) else $error("interrupt cause not recorded");

  p_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_store_ok |=> v_q[WB] && code_q[WB] == C_NONE) else $error("store allowed on dead instruction");
endmodule

// File: tb/exc_tracker_test.sv
module exc_tracker_test;
  logic clk = 0, rst_n = 0;
  logic if_valid = 0, if_fetch_fault = 0, if_in_slot = 0, id_is_eret = 0, br_squash = 0;
  logic ex_illegal = 0, ex_overflow = 0, mem_addr_fault = 0, mem_store = 0, ext_irq = 0;
  logic [31:0] if_pc = 0;
  logic redirect, mem_store_ok, wb_write_ok, kernel_mode, irq_enable;
  logic [31:0] redirect_pc, epc;
  logic [3:0] cause;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  exc_tracker uut (.clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_fetch_fault(if_fetch_fault), .if_in_slot(if_in_slot), .id_is_eret(id_is_eret),
    .br_squash(br_squash), .ex_illegal(ex_illegal), .ex_overflow(ex_overflow),
    .mem_addr_fault(mem_addr_fault), .mem_store(mem_store), .ext_irq(ext_irq),
    .redirect(redirect), .redirect_pc(redirect_pc), .mem_store_ok(mem_store_ok),
    .wb_write_ok(wb_write_ok), .epc(epc), .cause(cause), .kernel_mode(kernel_mode),
    .irq_enable(irq_enable));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk); #1;
    if_valid = 0; if_fetch_fault = 0; if_in_slot = 0; id_is_eret = 0; br_squash = 0;
    ex_illegal = 0; ex_overflow = 0; mem_addr_fault = 0; mem_store = 0; ext_irq = 0;
  endtask

  task automatic f(input logic [31:0] pc);
    if_valid = 1; if_pc = pc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go();
  endtask

  task automatic do_eret(input logic [31:0] pc, input logic [31:0] target);
    f(pc); go();
    f(pc + 4); id_is_eret = 1; go();
    f(pc + 8); go();
    f(pc + 12); go();
    #1; chk("R9 eret redirect", redirect, 1); chk("R9 eret target", redirect_pc, target);
    go();
    #1; chk("R9 user mode", kernel_mode, 0); chk("R9 irq enabled", irq_enable, 1);
    chk("R9 younger flushed", wb_write_ok, 0);
    idle(4);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 kernel", kernel_mode, 1); chk("R1 ie", irq_enable, 0);
    chk("R1 epc", epc, 0); chk("R1 cause", cause, 0);
    chk("R1 redirect", redirect, 0); chk("R1 write", wb_write_ok, 0);
  endtask

  task automatic t_illegal();
    f(32'h100); go();
    f(32'h104); go();
    f(32'h108); ex_illegal = 1; go();
    f(32'h10c); go();
    f(32'h110); mem_store = 1; #1;
    chk("R3 redirect at WB", redirect, 1); chk("R3 handler", redirect_pc, 32'h80);
    chk("R3 no write", wb_write_ok, 0); chk("R11 store blocked", mem_store_ok, 0);
    go();
    f(32'h80); #1;
    chk("R7 epc", epc, 32'h100); chk("R8 cause illegal", cause, 2);
    chk("R8 kernel", kernel_mode, 1); chk("R8 ie", irq_enable, 0);
    chk("R4 younger flushed", wb_write_ok, 0); chk("R4 no redirect", redirect, 0);
    go(); idle(5);
  endtask

  task automatic t_oldest();
    f(32'h300); go();
    f(32'h304); if_fetch_fault = 1; go();
    f(32'h308); ex_overflow = 1; go();
    f(32'h30c); ex_illegal = 1; go();
    #1; chk("R3 oldest redirect", redirect, 1); go();
    #1; chk("R2 overflow code", cause, 3); chk("R7 oldest epc", epc, 32'h300);
    chk("R4 younger fault dropped", redirect, 0);
    idle(5);
  endtask

  task automatic t_keep();
    f(32'h310); if_fetch_fault = 1; go();
    go();
    ex_illegal = 1; go();
    mem_addr_fault = 1; go();
    #1; chk("R3 keep redirect", redirect, 1); go();
    #1; chk("R2 earliest code kept", cause, 1); chk("R7 keep epc", epc, 32'h310);
    idle(5);
  endtask

  task automatic t_squash();
    f(32'h400); if_fetch_fault = 1; go();
    f(32'h404); br_squash = 1; go();
    f(32'h408); go();
    f(32'h40c); go();
    #1; chk("R6 squashed fault dropped", redirect, 0); chk("R6 squashed no write", wb_write_ok, 0);
    go();
    #1; chk("R6 second squashed", wb_write_ok, 0); go();
    #1; chk("R5 next completes", wb_write_ok, 1); chk("R6 cause unchanged", cause, 1);
    idle(5);
  endtask

  task automatic t_slot();
    f(32'h500); go();
    f(32'h504); if_in_slot = 1; go();
    f(32'h508); go();
    f(32'h50c); go();
    mem_addr_fault = 1; mem_store = 1; #1;
    chk("R5 branch completes", wb_write_ok, 1); chk("R5 no redirect", redirect, 0);
    chk("R11 faulting store blocked", mem_store_ok, 0);
    go();
    #1; chk("R3 slot redirect", redirect, 1); go();
    #1; chk("R7 slot epc", epc, 32'h500); chk("R2 data code", cause, 4);
    idle(5);
  endtask

  task automatic t_irq();
    f(32'h600); go();
    go();
    go();
    mem_store = 1; #1; chk("R11 plain store ok", mem_store_ok, 1); go();
    ext_irq = 1; #1;
    chk("R10 masked irq", redirect, 0); chk("R10 masked completes", wb_write_ok, 1);
    go(); idle(4);
    do_eret(32'h680, 32'h500);
    f(32'h700); go(); go();
    ex_illegal = 1; go(); go();
    ext_irq = 1; #1; chk("R10 internal wins redirect", redirect, 1); go();
    #1; chk("R10 internal wins cause", cause, 2); chk("R10 internal epc", epc, 32'h700);
    idle(4);
    do_eret(32'h780, 32'h700);
    f(32'h800); go(); go(); go(); go();
    ext_irq = 1; #1;
    chk("R10 irq redirect", redirect, 1); chk("R10 irq aborts", wb_write_ok, 0);
    chk("R10 irq handler", redirect_pc, 32'h80);
    go();
    #1; chk("R10 irq epc", epc, 32'h800); chk("R10 irq cause", cause, 5);
    chk("R8 irq ie off", irq_enable, 0); chk("R8 irq kernel", kernel_mode, 1);
    idle(4);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_illegal();
    do_eret(32'h200, 32'h100);
    t_oldest();
    do_eret(32'h380, 32'h300);
    t_keep();
    t_squash();
    t_slot();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule